// File: doc/BRIEF.md
# Indexed Palette Color Lookup with Sequential Component Loading

This block holds a 256-entry color table for an 8-bit indexed framebuffer and
turns each pixel index from the display pipeline into a 24-bit RGB value. Software
fills the table through a 32-bit write port that decodes a window of four word
registers. One register points at a table entry. A second register takes one
color byte per write. Successive writes fill red, green and blue in that order.
Once blue is written, the pointer moves to the next entry, so a whole palette can
be streamed after a single pointer write.

The display side has its own read port. It presents a pixel index every clock and
receives the matching color one clock later. This port never stalls and never
waits on the write side. A write and a lookup of the same entry in one cycle
return the color as it stood before the write.

Top module: `pal_dac`

## Requirements
- R1: After reset, every entry reads as black (0x000000) except entry 255, which reads as white (0xFFFFFF).
- R2: The register is chosen by address bits [3:2] only. Bits [1:0] of the address have no effect on decoding.
- R3: A write to register 0 loads the entry pointer from data bits [31:24] and returns the component phase to red.
- R4: Each write to register 1 stores data bits [31:24] into one component of the entry under the pointer. The first such write after a pointer load fills red, the second fills green and the third fills blue.
- R5: The write that fills blue advances the pointer by one and returns the phase to red, so the next three writes fill the following entry.
- R6: Writes to registers 2 and 3 change neither the table, the pointer nor the phase.
- R7: The lookup output is registered. One clock after an index is presented, `px_rgb` holds that entry as red in bits [23:16], green in [15:8] and blue in [7:0].
- R8: A lookup presented in the same cycle as a write to that entry returns the value from before the write.
- R9: The pointer advance after blue wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 4 | Byte address inside the register window |
| wr_data | input | 32 | Write data; the payload byte is in [31:24] |
| px_index | input | 8 | Pixel index to look up |
| px_rgb | output | 24 | Registered color of the index presented on the previous clock |

## Verification
The pointer and the phase are internal, so a fault in either shows up only when a color is read back. A phase that skips or repeats puts a byte into the wrong channel of the entry. A pointer that fails to advance or wrap makes the next three bytes overwrite the same entry or land in the wrong one. Either fault appears at `px_rgb` on the clock after that entry is looked up. Because of this, the bench reads back every entry it writes, and it also reads the neighbouring entries that the fault would have left untouched.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;

  // Component phase of the data register; the order is the loading sequence.
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  // Register numbers inside the four-word window.
  localparam logic [1:0] REG_INDEX = 2'd0;
  localparam logic [1:0] REG_DATA  = 2'd1;

  // Phase sequence: red -> green -> blue -> red.
  function automatic phase_e next_phase(input phase_e ph);
    case (ph)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction

  // Word register number taken from a byte address.
  function automatic logic [1:0] reg_of(input logic [3:0] byte_addr);
    return byte_addr[3:2];
  endfunction

endpackage

// File: rtl/pal_dac_ctrl.sv
module pal_dac_ctrl
  import pal_dac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              comp_we,
  output phase_e            comp_sel,
  output logic [IDX_W-1:0]  comp_idx,
  output logic [COMP_W-1:0] comp_val
);

  logic [1:0]       reg_sel;
  logic             idx_load;
  logic             data_put;
  logic [IDX_W-1:0] idx_q;
  phase_e           phase_q;

  assign reg_sel  = reg_of(wr_addr[3:0]);
  assign idx_load = wr_en && (reg_sel == REG_INDEX);
  assign data_put = wr_en && (reg_sel == REG_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (idx_load) begin
      idx_q   <= wr_data[DATA_W-1 -: IDX_W];
      phase_q <= PH_RED;
    end else if (data_put) begin
      phase_q <= next_phase(phase_q);
      if (phase_q == PH_BLU) idx_q <= idx_q + 1'b1;
    end
  end

  assign comp_we  = data_put;
  assign comp_sel = phase_q;
  assign comp_idx = idx_q;
  assign comp_val = wr_data[DATA_W-1 -: COMP_W];

  // R3: pointer load takes the top byte and restarts at red
  p_index_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> (idx_q == $past(wr_data[DATA_W-1 -: IDX_W])) && (phase_q == PH_RED));

  // R4: red and green writes step the phase and keep the pointer
  p_phase_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_put && phase_q != PH_BLU) |=>
      (idx_q == $past(idx_q)) && (phase_q == next_phase($past(phase_q))));

  // R5: the blue write advances the pointer (wrapping, R9) and returns to red
  p_blue_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_put && phase_q == PH_BLU) |=>
      (idx_q == IDX_W'($past(idx_q) + 1'b1)) && (phase_q == PH_RED));

  // R6: writes to the upper two registers leave the state alone
  p_ignored_regs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel[1]) |=> $stable(idx_q) && $stable(phase_q));

  // R4: the phase never takes the unused encoding
  always_comb begin
    if (rst_n) p_phase_legal_r4: assert (phase_q != phase_e'(2'd3));
  end

endmodule

// File: rtl/pal_dac_table.sv
module pal_dac_table
  import pal_dac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                comp_we,
  input  phase_e              comp_sel,
  input  logic [IDX_W-1:0]    comp_idx,
  input  logic [COMP_W-1:0]   comp_val,
  input  logic [IDX_W-1:0]    px_index,
  output logic [3*COMP_W-1:0] px_rgb
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int NCOMP = 3;

  // One plane per component; plane 0 (red) drives the top byte of the output.
  for (genvar c = 0; c < NCOMP; c++) begin : g_plane
    logic [COMP_W-1:0] mem [DEPTH];
    logic [COMP_W-1:0] rd_q;
    logic              hit;

    assign hit = comp_we && (comp_sel == phase_e'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= (i == DEPTH - 1) ? '1 : '0;
        rd_q <= '0;
      end else begin
        if (hit) mem[comp_idx] <= comp_val;
        rd_q <= mem[px_index];
      end
    end

    assign px_rgb[(NCOMP-1-c)*COMP_W +: COMP_W] = rd_q;
  end

  // One cycle after reset before history-based checks apply.
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R7: with a steady index and no write landing, the output holds
  p_lookup_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $stable(px_index) && !$past(comp_we)) |=> $stable(px_rgb));

endmodule

// File: rtl/pal_dac.sv
module pal_dac
  import pal_dac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]    px_index,
  output logic [3*COMP_W-1:0] px_rgb
);

  logic              comp_we;
  phase_e            comp_sel;
  logic [IDX_W-1:0]  comp_idx;
  logic [COMP_W-1:0] comp_val;

  pal_dac_ctrl #(
    .IDX_W(IDX_W), .COMP_W(COMP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .comp_we(comp_we), .comp_sel(comp_sel), .comp_idx(comp_idx), .comp_val(comp_val)
  );

  pal_dac_table #(
    .IDX_W(IDX_W), .COMP_W(COMP_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .comp_we(comp_we), .comp_sel(comp_sel),
    .comp_idx(comp_idx), .comp_val(comp_val), .px_index(px_index), .px_rgb(px_rgb)
  );

endmodule

// File: tb/pal_dac_bench.sv
module pal_dac_bench;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  px_index = '0;
  logic [23:0] px_rgb;

  pal_dac u_pal_dac (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .px_index(px_index), .px_rgb(px_rgb)
  );

  always #(PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference model of the table and of the pointer/phase sequence.
  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  logic [7:0] m_idx;
  int         m_ph;

  typedef struct {
    int          due;
    logic [23:0] exp;
    string       tag;
  } item_t;
  item_t q [$];

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      m_r[i] = (i == 255) ? 8'hFF : 8'h00;
      m_g[i] = (i == 255) ? 8'hFF : 8'h00;
      m_b[i] = (i == 255) ? 8'hFF : 8'h00;
    end
    m_idx = 8'd0;
    m_ph  = 0;
  endtask

  task automatic model_write(input logic [3:0] a, input logic [31:0] d);
    case (a[3:2])
      2'd0: begin m_idx = d[31:24]; m_ph = 0; end
      2'd1: begin
        if (m_ph == 0)      m_r[m_idx] = d[31:24];
        else if (m_ph == 1) m_g[m_idx] = d[31:24];
        else                m_b[m_idx] = d[31:24];
        if (m_ph == 2) begin m_ph = 0; m_idx = m_idx + 8'd1; end
        else m_ph = m_ph + 1;
      end
      default: ;
    endcase
  endtask

  // Driver: one cycle of stimulus; a lookup pushes its expected color first,
  // so a write in the same cycle does not change it (R8).
  task automatic step(input bit wr, input logic [3:0] a, input logic [31:0] d,
                      input bit lk, input logic [7:0] li, input string tag);
    @(negedge clk);
    wr_en   = wr;
    wr_addr = a;
    wr_data = d;
    if (lk) begin
      px_index = li;
      q.push_back('{cyc + 1, {m_r[li], m_g[li], m_b[li]}, tag});
    end
    if (wr) model_write(a, d);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] b);
    step(1'b1, a, {b, 24'h5A5A5A}, 1'b0, 8'd0, "");
  endtask

  task automatic look(input logic [7:0] li, input string tag);
    step(1'b0, 4'h0, 32'h0, 1'b1, li, tag);
  endtask

  // Monitor: compares each lookup on the cycle its result is due.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      total++;
      if (px_rgb !== q[0].exp) begin
        bad++;
        $display("FAIL %s: px_rgb=%06h expected=%06h", q[0].tag, px_rgb, q[0].exp);
      end
      void'(q.pop_front());
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    look(8'd0, "R1 entry 0");
    look(8'd100, "R1 entry 100");
    look(8'd254, "R1 entry 254");
    look(8'd255, "R1 entry 255");

    // R3/R4/R7: load entry 10 with red, green, blue
    wr(4'h0, 8'd10);
    wr(4'h4, 8'h12);
    wr(4'h4, 8'h34);
    wr(4'h4, 8'h56);
    look(8'd10, "R4 entry 10 components in order");
    look(8'd11, "R4 neighbour 11 untouched");
    look(8'd9, "R7 neighbour 9 untouched");

    // R5: the next three bytes land in entry 11
    wr(4'h4, 8'hA1);
    wr(4'h4, 8'hB2);
    wr(4'h4, 8'hC3);
    look(8'd11, "R5 auto-advance to 11");
    look(8'd10, "R5 entry 10 kept");

    // R3: a pointer write mid-sequence restarts at red
    wr(4'h0, 8'd20);
    wr(4'h4, 8'h77);
    wr(4'h0, 8'd21);
    wr(4'h4, 8'h88);
    wr(4'h4, 8'h99);
    wr(4'h4, 8'hAA);
    look(8'd20, "R3 partial entry 20");
    look(8'd21, "R3 phase restart on 21");

    // R2: low address bits ignored (0x3 -> reg0, 0x5/0x6/0x7 -> reg1)
    wr(4'h3, 8'd40);
    wr(4'h5, 8'h01);
    wr(4'h6, 8'h02);
    wr(4'h7, 8'h03);
    look(8'd40, "R2 low address bits ignored");

    // R6: registers 2 and 3 do nothing; then data goes on at entry 41 red
    wr(4'h8, 8'd50);
    wr(4'hC, 8'hEE);
    wr(4'hB, 8'hDD);
    wr(4'h4, 8'h44);
    wr(4'h4, 8'h55);
    wr(4'h4, 8'h66);
    look(8'd41, "R6 upper registers ignored");
    look(8'd50, "R6 entry 50 untouched");
    look(8'd40, "R6 entry 40 kept");

    // R9: wrap from 255 to 0
    wr(4'h0, 8'd255);
    wr(4'h4, 8'h10);
    wr(4'h4, 8'h20);
    wr(4'h4, 8'h30);
    wr(4'h4, 8'h0F);
    wr(4'h4, 8'h0E);
    wr(4'h4, 8'h0D);
    look(8'd255, "R9 entry 255 rewritten");
    look(8'd0, "R9 wrap to entry 0");
    look(8'd1, "R9 entry 1 untouched");

    // R8: lookup in the same cycle as the blue write of entry 60
    wr(4'h0, 8'd60);
    wr(4'h4, 8'hC0);
    wr(4'h4, 8'hC1);
    step(1'b1, 4'h4, {8'hC2, 24'h0}, 1'b1, 8'd60, "R8 old value on collision");
    look(8'd60, "R8 new value next cycle");

    // R7: back-to-back lookups of different entries
    look(8'd11, "R7 back-to-back a");
    look(8'd255, "R7 back-to-back b");
    look(8'd10, "R7 back-to-back c");

    repeat (3) step(1'b0, 4'h0, 32'h0, 1'b0, 8'd0, "");
    if (q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R7: %0d results pending, expected 0", q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule